// File: doc/BRIEF.md
# Unaligned Load Byte-Merge Unit

This block forms the register writeback value for the two partial-word load operations of a little-endian 32-bit core. A "left" partial load replaces the top bytes of the destination register with memory bytes. A "right" partial load replaces the bottom bytes. The rest of the register keeps its old contents. Software reaches an arbitrary unaligned word by issuing a right load at the lowest byte address, followed by a left load at the highest byte address.

Memory is little-endian: byte address 4n+k holds byte k of aligned word n. The unit receives the aligned word that holds the addressed byte, the low address bits that steer the byte lanes, and the register-file value of the destination. A load issued by the previous instruction may still be waiting in its delay slot. If that load targets the same register, the unit merges into that load's fresh value, not the stale register-file copy. In the same cycle it raises a cancel so that the earlier load's delayed writeback is dropped.

The merge is combinational. A small tracking register remembers the last load's destination and value for exactly one following instruction.

Top module: `partial_load_merge`

## Requirements
- R1: Synchronous reset (`rst`=1) clears the pending-load tracker. The first partial load after reset merges into `rf_value` with `cancel_pending`=0, even if a load was presented during reset.
- R2: When `in_op`=2'b10 (left) and `in_ofs`=k, result bytes 3 down to 3-k take memory bytes k down to 0. For example, with old 0xDEADBEEF and word 0x77665544, offset 2 gives 0x665544EF and offset 0 gives 0x44ADBEEF.
- R3: When `in_op`=2'b11 (right) and `in_ofs`=k, result bytes 0 up to 3-k take memory bytes k up to 3. For example, with old 0xDEADBEEF and word 0x33221100, offset 3 gives 0xDEADBE33 and offset 1 gives 0xDE332211.
- R4: Result bytes that no memory byte replaces equal the old register value. A left load keeps the 3-k low bytes, and a right load keeps the k high bytes.
- R5: `res_valid` equals 1 in the same cycle exactly when `in_valid`=1 and `in_op` is 2'b10 or 2'b11. The codes 2'b00 (non-load) and 2'b01 (full-word load) never raise it.
- R6: The bypass condition holds when the previous valid instruction was a load of any kind (2'b01, 2'b10 or 2'b11) to the same `in_dest`. In that case the old value used is that load's writeback value: `mem_word` for a full load, or the merged result for a partial load.
- R7: `cancel_pending` is 1 in the same cycle as a partial load that meets the bypass condition, and 0 in every other cycle.
- R8: The pending load is tracked for one valid instruction only. Cycles with `in_valid`=0 leave it in place. A different destination, or an intervening instruction, gives no bypass.
- R9: A right load at byte address 1 followed at once by a left load at address 4 to the same register yields 0x44332211, with memory bytes 0x00, 0x11, … at addresses 0, 1, …

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the tracker |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_op | input | 2 | 00 other, 01 full load, 10 left load, 11 right load |
| in_dest | input | 5 | Destination register index |
| in_ofs | input | 2 | Low byte-address bits |
| mem_word | input | 32 | Aligned memory word |
| rf_value | input | 32 | Register-file value of the destination |
| res_valid | output | 1 | Merged result is valid |
| res_data | output | 32 | Merged register value |
| cancel_pending | output | 1 | Drop the earlier load's delayed writeback |

## Verification
The bench aims at the offset extremes, where a left load at offset 3 or a right load at offset 0 must pass the whole word through. A lane-arithmetic error there shows up as a stale or rotated byte. It chains a partial load onto a full load and onto another partial load to the same register. A unit that ignored the bypass would merge into the stale register value, and a unit that failed to cancel would let the delay-slot value overwrite the merged word. It also places idle cycles, different destinations and non-load instructions between loads, and issues a load during reset. A tracker that expired wrongly or ignored reset would then cancel, or fail to cancel, at the wrong time.

// File: rtl/plm_pkg.sv
package plm_pkg;
  typedef enum logic [1:0] {
    OP_OTHER = 2'b00,
    OP_WORD  = 2'b01,
    OP_LEFT  = 2'b10,
    OP_RIGHT = 2'b11
  } plm_op_e;

  // lane receives a memory byte: left fills from the top, right from the bottom
  function automatic logic plm_lane_taken(int lane, int ofs, logic left, int nb);
    if (left) return (lane + ofs + 1) >= nb;
    return (lane + ofs) < nb;
  endfunction

  // source memory lane, to be reduced modulo the lane count by the caller
  function automatic int plm_lane_src(int lane, int ofs, logic left);
    return lane + ofs + (left ? 1 : 0);
  endfunction
endpackage

// File: rtl/plm_byte_lanes.sv
module plm_byte_lanes
  import plm_pkg::*;
#(
  parameter int NB = 4,
  localparam int OW = (NB > 1) ? $clog2(NB) : 1,
  localparam int DW = NB * 8
) (
  input  logic          is_left,
  input  logic [OW-1:0] ofs,
  input  logic [DW-1:0] mem_word,
  input  logic [DW-1:0] old_word,
  output logic [NB-1:0] lane_take,
  output logic [DW-1:0] merged
);
  logic [7:0] mem_b [NB];

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [OW-1:0] src;
    assign mem_b[i]     = mem_word[i*8 +: 8];
    assign lane_take[i] = plm_lane_taken(i, int'(ofs), is_left, NB);
    assign src          = OW'(plm_lane_src(i, int'(ofs), is_left));
    assign merged[i*8 +: 8] = lane_take[i] ? mem_b[src] : old_word[i*8 +: 8];
  end
endmodule

// File: rtl/plm_hazard.sv
module plm_hazard #(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          is_load,
  input  logic          is_partial,
  input  logic [RW-1:0] dest,
  input  logic [DW-1:0] rf_value,
  input  logic [DW-1:0] wb_value,
  output logic [DW-1:0] old_sel,
  output logic          hit,
  output logic          pend_v
);
  logic [RW-1:0] pend_dest;
  logic [DW-1:0] pend_data;

  assign hit     = in_valid && is_partial && pend_v && (pend_dest == dest);
  assign old_sel = hit ? pend_data : rf_value;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v    <= 1'b0;
      pend_dest <= '0;
      pend_data <= '0;
    end else if (in_valid) begin
      pend_v    <= is_load;
      pend_dest <= dest;
      pend_data <= wb_value;
    end
  end

  a_r8_slot_expires: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_load) |=> !pend_v);
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!in_valid) |=> (pend_v == $past(pend_v)));
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pend_v);
endmodule

// File: rtl/partial_load_merge.sv
module partial_load_merge
  import plm_pkg::*;
#(
  parameter int NB = 4,
  parameter int RW = 5,
  localparam int OW = (NB > 1) ? $clog2(NB) : 1,
  localparam int DW = NB * 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic [RW-1:0] in_dest,
  input  logic [OW-1:0] in_ofs,
  input  logic [DW-1:0] mem_word,
  input  logic [DW-1:0] rf_value,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic          cancel_pending
);
  plm_op_e       op;
  logic          is_left, is_partial, is_load;
  logic [DW-1:0] old_word, merged, wb_value;
  logic [NB-1:0] lane_take;
  logic          bypass_hit, pend_v;

  assign op         = plm_op_e'(in_op);
  assign is_left    = (op == OP_LEFT);
  assign is_partial = (op == OP_LEFT) || (op == OP_RIGHT);
  assign is_load    = (op != OP_OTHER);
  assign wb_value   = is_partial ? merged : mem_word;

  plm_byte_lanes #(.NB(NB)) u_lanes (
    .is_left  (is_left),
    .ofs      (in_ofs),
    .mem_word (mem_word),
    .old_word (old_word),
    .lane_take(lane_take),
    .merged   (merged)
  );

  plm_hazard #(.RW(RW), .DW(DW)) u_hazard (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .is_load   (is_load),
    .is_partial(is_partial),
    .dest      (in_dest),
    .rf_value  (rf_value),
    .wb_value  (wb_value),
    .old_sel   (old_word),
    .hit       (bypass_hit),
    .pend_v    (pend_v)
  );

  assign res_valid      = in_valid && is_partial;
  assign res_data       = merged;
  assign cancel_pending = bypass_hit;

  a_r7_cancel_with_result: assert property (@(posedge clk) disable iff (rst)
    cancel_pending |-> (res_valid && pend_v));
  a_r2_left_top_offset: assert property (@(posedge clk) disable iff (rst)
    (res_valid && is_left && in_ofs == OW'(NB-1)) |-> (res_data == mem_word));
  a_r3_right_zero_offset: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !is_left && in_ofs == '0) |-> (res_data == mem_word));
  a_r4_left_keeps_low: assert property (@(posedge clk) disable iff (rst)
    (res_valid && is_left && in_ofs != OW'(NB-1)) |-> (res_data[7:0] == old_word[7:0]));
  a_r4_right_keeps_high: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !is_left && in_ofs != '0) |-> (res_data[DW-1 -: 8] == old_word[DW-1 -: 8]));
  a_r2_lane_count: assert property (@(posedge clk) disable iff (rst)
    (res_valid && is_left) |-> ($countones(lane_take) == int'(in_ofs) + 1));
endmodule

// File: tb/partial_load_merge_test.sv
module partial_load_merge_test;
  logic clk = 0, rst = 1;
  logic in_valid = 0;
  logic [1:0] in_op = 0;
  logic [4:0] in_dest = 0;
  logic [1:0] in_ofs = 0;
  logic [31:0] mem_word = 0, rf_value = 0;
  logic res_valid, cancel_pending;
  logic [31:0] res_data;

  int n_chk = 0, n_fail = 0;
  bit m_pv = 0;
  logic [4:0] m_pd = 0;
  logic [31:0] m_pdat = 0;

  always #5 clk = ~clk;

  partial_load_merge uut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_dest(in_dest), .in_ofs(in_ofs), .mem_word(mem_word), .rf_value(rf_value),
    .res_valid(res_valid), .res_data(res_data), .cancel_pending(cancel_pending));

  function automatic logic [31:0] ref_merge(bit left, int k, logic [31:0] mw, logic [31:0] old);
    logic [31:0] r = old;
    if (left) for (int j = 0; j <= k; j++) r[(3-j)*8 +: 8] = mw[(k-j)*8 +: 8];
    else      for (int j = 0; j <= 3-k; j++) r[j*8 +: 8] = mw[(k+j)*8 +: 8];
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(bit v, logic [1:0] op, logic [4:0] d, logic [1:0] k,
                      logic [31:0] mw, logic [31:0] rf, string req);
    bit part, hit;
    logic [31:0] old, exp;
    @(negedge clk);
    in_valid = v; in_op = op; in_dest = d; in_ofs = k; mem_word = mw; rf_value = rf;
    #1;
    part = v && op[1];
    hit  = part && m_pv && (m_pd == d);
    old  = hit ? m_pdat : rf;
    exp  = ref_merge(op == 2'b10, int'(k), mw, old);
    chk({req, " R5 valid"}, {31'd0, res_valid}, {31'd0, part});
    chk({req, " R7 cancel"}, {31'd0, cancel_pending}, {31'd0, hit});
    if (part) chk({req, " data"}, res_data, exp);
    if (v) begin
      m_pv = (op != 2'b00); m_pd = d; m_pdat = part ? exp : mw;
    end
  endtask

  initial begin
    #1000000;
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: a load presented during reset must not be tracked
    @(negedge clk);
    in_valid = 1; in_op = 2'b01; in_dest = 5'd3; mem_word = 32'hCAFEF00D;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; in_valid = 0;
    m_pv = 0;
    step(1, 2'b10, 5'd3, 2'd1, 32'h77665544, 32'hDEADBEEF, "R1 post-reset");
    step(0, 2'b00, 0, 0, 0, 0, "gap");
    step(1, 2'b00, 0, 0, 0, 0, "clear");
    // R2 examples
    step(1, 2'b10, 5'd1, 2'd2, 32'h77665544, 32'hDEADBEEF, "R2 ofs2");
    chk("R2 ofs2 value", res_data, 32'h665544EF);
    step(1, 2'b00, 0, 0, 0, 0, "clear");
    step(1, 2'b10, 5'd1, 2'd0, 32'h77665544, 32'hDEADBEEF, "R2 ofs0");
    chk("R2 ofs0 value", res_data, 32'h44ADBEEF);
    step(1, 2'b00, 0, 0, 0, 0, "clear");
    // R3 examples
    step(1, 2'b11, 5'd2, 2'd3, 32'h33221100, 32'hDEADBEEF, "R3 ofs3");
    chk("R3 ofs3 value", res_data, 32'hDEADBE33);
    step(1, 2'b00, 0, 0, 0, 0, "clear");
    step(1, 2'b11, 5'd2, 2'd1, 32'h33221100, 32'hDEADBEEF, "R3 ofs1");
    chk("R3 ofs1 value", res_data, 32'hDE332211);
    step(1, 2'b00, 0, 0, 0, 0, "clear");
    // R4 extremes: whole-word pass-through
    step(1, 2'b10, 5'd4, 2'd3, 32'h01234567, 32'hFFFFFFFF, "R4 left full");
    chk("R4 left full value", res_data, 32'h01234567);
    step(1, 2'b00, 0, 0, 0, 0, "clear");
    step(1, 2'b11, 5'd4, 2'd0, 32'h89ABCDEF, 32'h00000000, "R4 right full");
    chk("R4 right full value", res_data, 32'h89ABCDEF);
    step(1, 2'b00, 0, 0, 0, 0, "clear");
    // R9 chained right then left, with R6 bypass from partial
    step(1, 2'b11, 5'd7, 2'd1, 32'h33221100, 32'hDEADBEEF, "R9 right");
    step(1, 2'b10, 5'd7, 2'd0, 32'h77665544, 32'h0BADCAFE, "R9 left");
    chk("R9 assembled", res_data, 32'h44332211);
    chk("R9 R7 cancel", {31'd0, cancel_pending}, 32'd1);
    // R6 bypass from full load, across idle cycles (R8)
    step(1, 2'b01, 5'd9, 2'd0, 32'hA1B2C3D4, 32'h0, "R6 full");
    step(0, 2'b10, 5'd9, 2'd0, 32'h0, 32'h0, "R8 idle");
    step(0, 2'b00, 5'd9, 2'd0, 32'h0, 32'h0, "R8 idle");
    step(1, 2'b11, 5'd9, 2'd2, 32'h55667788, 32'h12345678, "R6 bypass");
    chk("R6 bypass value", res_data, 32'hA1B25566);
    // R8 different destination, then intervening instruction
    step(1, 2'b01, 5'd10, 2'd0, 32'h11111111, 32'h0, "R8 load");
    step(1, 2'b10, 5'd11, 2'd1, 32'h22222222, 32'h33333333, "R8 other dest");
    step(1, 2'b01, 5'd12, 2'd0, 32'h44444444, 32'h0, "R8 load2");
    step(1, 2'b00, 5'd12, 2'd0, 32'h0, 32'h0, "R8 between");
    step(1, 2'b10, 5'd12, 2'd1, 32'h55555555, 32'h66666666, "R8 expired");
    // constrained random
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 8) != 0, 2'($urandom), 5'($urandom % 3), 2'($urandom),
           $urandom, $urandom, "random R2 R3 R6");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule